// File: doc/BRIEF.md
# Oversampling SPI Slave Engine

This block is the slave end of an SPI link. It never uses the serial clock as a clock. The serial clock, the active-low select and the MOSI line are treated as plain data inputs. Each one passes through a two-register synchronizer in the system clock domain. Edges of the serial clock and of select are found by comparing two consecutive synchronized samples. The system clock must run at least twice as fast as the fastest serial clock the link uses.

A small state machine has four states: reset, wait-for-select, latch, and assert. On successive detected serial-clock edges it alternates between capturing MOSI and advancing the MISO bit. The clock phase setting decides how a word starts:

- **Phase 0:** the falling edge of select starts the word, and the first bit is already on MISO before any clock edge.
- **Phase 1:** the first leading clock edge seen while select is low starts the word.

The clock polarity setting defines which edge counts as leading.

A local response register holds the outgoing word. It is MSB-packed and is copied into the transmit shifter at the start of each word. The received word is presented LSB-packed, together with a one-cycle valid strobe.

Top module: `spi_os_slave`

## Requirements
- R1: While `rst` is high and in the cycle after, `rx_valid_o` is 0, `rx_word_o` is 0 and `miso_o` is 0. The machine then waits for select.
- R2: With `cpha_i`=0, a falling edge of `ssel_n_i` starts a word. Bit 31 of the response register is placed on `miso_o` before the first serial-clock edge.
- R3: With `cpha_i`=0, MOSI is captured on the 1st, 3rd, 5th and later odd serial-clock edges of the word. `miso_o` advances to the next lower response bit on the even edges.
- R4: With `cpha_i`=1, the first leading edge while `ssel_n_i` is low starts the word and drives bit 31 onto `miso_o`. A leading edge is the serial clock leaving the level `cpol_i`. After that, MOSI is captured on trailing edges and `miso_o` advances on leading edges.
- R5: A word is `word_len_i`+1 bits long (field 0..31 gives 1..32 bits). The length is taken when the word starts.
- R6: The received bits are LSB-packed into `rx_word_o`: the last bit received lands in bit 0, and unused upper bits are 0. `rx_word_o` changes only in the cycle where `rx_valid_o` is 1. `rx_valid_o` is high for exactly one cycle per completed word.
- R7: MISO sends the response register MSB first: bit 31, then bit 30, and so on down.
- R8: `resp_load_i`=1 writes `resp_i` into the response register. A write made during a word does not change the bits of that word; it takes effect from the next word.
- R9: `ssel_n_i` going high before the word completes aborts it. `rx_valid_o` is not raised, `rx_word_o` keeps its value, and the next word starts fresh.
- R10: With `cpol_i`=1 (idle-high clock) transfers behave exactly as with `cpol_i`=0, with the leading edge being falling.
- R11: Serial-clock edges while `ssel_n_i` is high start no word, raise no valid and leave `miso_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least twice the highest serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, sampled as data |
| ssel_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: capture on leading edges; 1: capture on trailing edges |
| word_len_i | input | 5 | Word length minus one |
| resp_i | input | 32 | Response word, MSB-packed |
| resp_load_i | input | 1 | Writes resp_i into the response register |
| miso_o | output | 1 | Serial data to the master |
| rx_word_o | output | 32 | Last completed received word, LSB-packed |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_word_o |

## Verification
The bench builds the block with its default 32-bit maximum word and two synchronizer stages. This makes both extremes of the length field reachable: single-bit and full 32-bit words. The serial clock half period is eight system clocks, well above the two-to-one minimum. That leaves room to compare MISO against the response register bit by bit just before each capture edge. All four polarity and phase combinations, mid-word aborts, mid-word response loads and clock activity with select high are driven as separate scenarios.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;
  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_LATCH  = 2'd2,
    ST_ASSERT = 2'd3
  } spi_st_t;
endpackage

// File: rtl/spi_os_sync.sv
// Per-bit synchronizer chains; each lane has its own reset level.
module spi_os_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], din[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_os_edge.sv
// Holds the previous synchronized sample so edges can be found.
module spi_os_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= cur;
  end
endmodule

// File: rtl/spi_os_ctrl.sv
module spi_os_ctrl
  import spi_os_pkg::*;
#(
  parameter int WMAX = 32,
  localparam int LW  = $clog2(WMAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [LW-1:0] len_field,
  input  logic          sclk_q,
  input  logic          sclk_edge,
  input  logic          sel_q,
  input  logic          sel_fall,
  output spi_st_t       st,
  output logic          load_tx,
  output logic          shift_tx,
  output logic          sample_rx,
  output logic          done
);
  logic [LW-1:0] cnt;
  logic          busy;
  logic          abort;
  logic          lead_edge;
  spi_st_t       st_nx;

  assign lead_edge = sclk_edge && (sclk_q != cpol);
  assign busy      = (st == ST_LATCH) || (st == ST_ASSERT);
  assign abort     = busy && sel_q;
  assign load_tx   = (st == ST_WAIT) &&
                     (cpha ? (!sel_q && lead_edge) : sel_fall);
  assign sample_rx = (st == ST_LATCH) && sclk_edge && !abort;
  assign shift_tx  = (st == ST_ASSERT) && sclk_edge && !abort;
  assign done      = sample_rx && (cnt == '0);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RESET:  st_nx = ST_WAIT;
      ST_WAIT:   if (load_tx) st_nx = ST_LATCH;
      ST_LATCH: begin
        if (abort)          st_nx = ST_WAIT;
        else if (done)      st_nx = ST_WAIT;
        else if (sample_rx) st_nx = ST_ASSERT;
      end
      ST_ASSERT: begin
        if (abort)         st_nx = ST_WAIT;
        else if (shift_tx) st_nx = ST_LATCH;
      end
      default:   st_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_RESET;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (load_tx)                cnt <= len_field;
      else if (sample_rx && !done) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_os_shift.sv
module spi_os_shift #(
  parameter int WMAX = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WMAX-1:0] resp,
  input  logic            resp_load,
  input  logic            mosi_q,
  input  logic            load_tx,
  input  logic            shift_tx,
  input  logic            sample_rx,
  input  logic            done,
  output logic            miso,
  output logic [WMAX-1:0] rx_word,
  output logic            rx_valid
);
  logic [WMAX-1:0] resp_q;
  logic [WMAX-1:0] tx_q;
  logic [WMAX-1:0] rx_q;
  logic [WMAX-1:0] rx_nx;

  assign rx_nx = {rx_q[WMAX-2:0], mosi_q};
  assign miso  = tx_q[WMAX-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (resp_load) resp_q <= resp;
      if (load_tx)       tx_q <= resp_q;
      else if (shift_tx) tx_q <= {tx_q[WMAX-2:0], 1'b0};
      if (load_tx)        rx_q <= '0;
      else if (sample_rx) rx_q <= rx_nx;
      if (done) rx_word <= rx_nx;
      rx_valid <= done;
    end
  end
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave
  import spi_os_pkg::*;
#(
  parameter int  WMAX        = 32,
  parameter int  SYNC_STAGES = 2,
  localparam int LW          = $clog2(WMAX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_i,
  input  logic            ssel_n_i,
  input  logic            mosi_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic [LW-1:0]   word_len_i,
  input  logic [WMAX-1:0] resp_i,
  input  logic            resp_load_i,
  output logic            miso_o,
  output logic [WMAX-1:0] rx_word_o,
  output logic            rx_valid_o
);
  logic [2:0] sq;
  logic [1:0] sprev;
  logic       sclk_q, sel_q, mosi_q;
  logic       sclk_edge, sel_fall;
  logic       load_tx, shift_tx, sample_rx, done;
  spi_st_t    st;

  spi_os_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .din({mosi_i, ssel_n_i, sclk_i}),
    .q(sq)
  );

  assign sclk_q = sq[0];
  assign sel_q  = sq[1];
  assign mosi_q = sq[2];

  spi_os_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst(rst), .cur(sq[1:0]), .prev(sprev)
  );

  assign sclk_edge = sclk_q ^ sprev[0];
  assign sel_fall  = sprev[1] & ~sel_q;

  spi_os_ctrl #(.WMAX(WMAX)) u_ctrl (
    .clk(clk), .rst(rst), .cpol(cpol_i), .cpha(cpha_i),
    .len_field(word_len_i), .sclk_q(sclk_q), .sclk_edge(sclk_edge),
    .sel_q(sel_q), .sel_fall(sel_fall), .st(st),
    .load_tx(load_tx), .shift_tx(shift_tx), .sample_rx(sample_rx),
    .done(done)
  );

  spi_os_shift #(.WMAX(WMAX)) u_shift (
    .clk(clk), .rst(rst), .resp(resp_i), .resp_load(resp_load_i),
    .mosi_q(mosi_q), .load_tx(load_tx), .shift_tx(shift_tx),
    .sample_rx(sample_rx), .done(done), .miso(miso_o),
    .rx_word(rx_word_o), .rx_valid(rx_valid_o)
  );
endmodule

// File: rtl/spi_os_chk.sv
module spi_os_chk
  import spi_os_pkg::*;
#(
  parameter int WMAX = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_valid_o,
  input logic [WMAX-1:0] rx_word_o,
  input logic            miso_o,
  input logic            sclk_edge,
  input logic            sel_fall,
  input logic            sel_q,
  input logic            cpha_i,
  input spi_st_t         st
);
  // R6: strobe lasts a single cycle
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  // R6: received word only moves together with the strobe
  assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_o |-> $stable(rx_word_o));

  // R9: completion only with select still low
  assert_valid_sel_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> !$past(sel_q));

  // R9: select high during a word returns to waiting
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_LATCH || st == ST_ASSERT) && sel_q) |=> (st == ST_WAIT));

  // R11: MISO moves only after a clock edge or a select fall
  assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $stable(miso_o) || $past(sclk_edge) || $past(sel_fall));

  // R2: phase 0 starts on select fall
  assert_start_cpha0_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !cpha_i && sel_fall) |=> (st == ST_LATCH));
endmodule

bind spi_os_slave spi_os_chk #(.WMAX(WMAX)) u_chk (
  .clk(clk), .rst(rst), .rx_valid_o(rx_valid_o), .rx_word_o(rx_word_o),
  .miso_o(miso_o), .sclk_edge(sclk_edge), .sel_fall(sel_fall),
  .sel_q(sel_q), .cpha_i(cpha_i), .st(st)
);

// File: tb/tb_spi_os_slave.sv
module tb_spi_os_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_i = 1'b0, ssel_n_i = 1'b1, mosi_i = 1'b0;
  logic        cpol_i = 1'b0, cpha_i = 1'b0;
  logic [4:0]  word_len_i = '0;
  logic [31:0] resp_i = '0;
  logic        resp_load_i = 1'b0;
  logic        miso_o;
  logic [31:0] rx_word_o;
  logic        rx_valid_o;

  int total = 0, bad = 0, vcnt = 0;
  logic [31:0] vlast = '0;
  logic [31:0] cur_resp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_os_slave dut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .ssel_n_i(ssel_n_i),
    .mosi_i(mosi_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .word_len_i(word_len_i), .resp_i(resp_i), .resp_load_i(resp_load_i),
    .miso_o(miso_o), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  always @(posedge clk) if (!rst && rx_valid_o) begin
    vcnt  = vcnt + 1;
    vlast = rx_word_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_resp(input logic [31:0] v);
    resp_i = v; resp_load_i = 1'b1;
    cyc(1);
    resp_load_i = 1'b0;
  endtask

  // One full word; ldk >= 0 writes ldv into the response register mid-word (phase 0 only)
  task automatic xfer(input string tag, input logic pol, input logic pha, input int len,
                      input logic [31:0] mw, input int ldk, input logic [31:0] ldv);
    logic [31:0] got, expm, mask, exprx;
    int v0;
    got = '0;
    mask = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
    expm = cur_resp & ~(32'hFFFF_FFFF >> len);
    exprx = mw & mask;
    cpol_i = pol; cpha_i = pha; sclk_i = pol; word_len_i = 5'(len - 1);
    cyc(H);
    v0 = vcnt;
    if (!pha) mosi_i = mw[len-1];
    ssel_n_i = 1'b0;
    cyc(H);
    for (int k = 0; k < len; k++) begin
      if (!pha) begin
        got[31-k] = miso_o;
        sclk_i = ~pol;
        if (k == ldk) begin load_resp(ldv); cyc(H-1); end
        else cyc(H);
        sclk_i = pol;
        if (k < len-1) mosi_i = mw[len-2-k];
        cyc(H);
      end else begin
        sclk_i = ~pol;
        mosi_i = mw[len-1-k];
        cyc(H);
        got[31-k] = miso_o;
        sclk_i = pol;
        cyc(H);
      end
    end
    ssel_n_i = 1'b1;
    cyc(H);
    chk({tag, " R7 miso bits"}, got, expm);
    chk({tag, " R6 one valid"}, 32'(vcnt - v0), 32'd1);
    chk({tag, " R6 strobed word"}, vlast, exprx);
    chk({tag, " R5 rx_word"}, rx_word_o, exprx);
  endtask

  task automatic t_reset;
    chk("R1 rx_valid", {31'd0, rx_valid_o}, 32'd0);
    chk("R1 rx_word", rx_word_o, 32'd0);
    chk("R1 miso", {31'd0, miso_o}, 32'd0);
    chk("R1 no strobe", 32'(vcnt), 32'd0);
  endtask

  task automatic t_modes;
    load_resp(32'hA5C3_0F96); cur_resp = 32'hA5C3_0F96;
    xfer("R2 R3 m0 len8", 1'b0, 1'b0, 8, 32'h0000_00B4, -1, '0);
    xfer("R10 m2 len8", 1'b1, 1'b0, 8, 32'h0000_005A, -1, '0);
    xfer("R4 m1 len8", 1'b0, 1'b1, 8, 32'h0000_00C9, -1, '0);
    xfer("R4 R10 m3 len13", 1'b1, 1'b1, 13, 32'h0000_1A3D, -1, '0);
    xfer("R5 len32", 1'b0, 1'b0, 32, 32'hDEAD_BEEF, -1, '0);
    xfer("R5 len1", 1'b0, 1'b0, 1, 32'h0000_0001, -1, '0);
    xfer("R5 R4 len1 m1", 1'b0, 1'b1, 1, 32'h0000_0001, -1, '0);
    load_resp(32'h1234_5678); cur_resp = 32'h1234_5678;
    xfer("R3 len16", 1'b0, 1'b0, 16, 32'h0000_8001, -1, '0);
  endtask

  task automatic t_midload;
    xfer("R8 midload", 1'b0, 1'b0, 16, 32'h0000_3C3C, 4, 32'hF0F0_0FF0);
    cur_resp = 32'hF0F0_0FF0;
    xfer("R8 next word", 1'b0, 1'b0, 16, 32'h0000_7E81, -1, '0);
  endtask

  task automatic t_abort;
    logic [31:0] w0;
    int v0;
    cpol_i = 1'b0; cpha_i = 1'b0; sclk_i = 1'b0; word_len_i = 5'd15;
    cyc(H);
    w0 = rx_word_o; v0 = vcnt;
    mosi_i = 1'b1; ssel_n_i = 1'b0;
    cyc(H);
    for (int k = 0; k < 5; k++) begin
      sclk_i = 1'b1; cyc(H);
      sclk_i = 1'b0; cyc(H);
    end
    ssel_n_i = 1'b1;
    cyc(2*H);
    chk("R9 abort no valid", 32'(vcnt - v0), 32'd0);
    chk("R9 abort word kept", rx_word_o, w0);
    xfer("R9 after abort", 1'b0, 1'b0, 8, 32'h0000_0066, -1, '0);
  endtask

  task automatic t_ignore;
    logic m0;
    int v0;
    for (int p = 0; p < 2; p++) begin
      cpol_i = 1'b0; cpha_i = p[0]; sclk_i = 1'b0; ssel_n_i = 1'b1;
      cyc(H);
      m0 = miso_o; v0 = vcnt;
      for (int k = 0; k < 6; k++) begin
        sclk_i = ~sclk_i; mosi_i = ~mosi_i; cyc(H);
      end
      cyc(H);
      chk("R11 no valid", 32'(vcnt - v0), 32'd0);
      chk("R11 miso held", {31'd0, miso_o}, {31'd0, m0});
    end
    xfer("R11 after idle clocks", 1'b0, 1'b0, 8, 32'h0000_0093, -1, '0);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_modes();
    t_midload();
    t_abort();
    t_ignore();
    finish_run();
  end
endmodule